// File: doc/BRIEF.md
# Downward Stack Pointer Controller

This block keeps a last-in, first-out stack in a small synchronous RAM and owns the stack pointer that addresses it. The stack grows from the highest address toward address zero. A requester offers one operation at a time over a valid/ready handshake. The operation is either a push, which carries a data word, or a pop. The controller then runs that operation as two ordered steps: it moves the pointer and it accesses the RAM. Popped words come back on a separate output with a one-cycle valid strobe, and plain full and empty flags report how much of the stack is in use.

A static mode pin selects the pointer convention. In last-occupied mode the pointer addresses the word most recently pushed. In next-free mode it addresses the slot that the next push will fill. The convention decides which step comes first. In last-occupied mode a push moves the pointer before it writes, and a pop reads before it moves the pointer. In next-free mode both orders are reversed. The requester must hold `in_valid` with stable `in_op` and `in_data` until it sees `in_ready` high at a clock edge. While an operation is in progress, `in_ready` stays low and applies back-pressure. The result stream has no back-pressure, so the consumer must take each strobed pop word in the cycle it appears.

Top module: `lifo_sp_ctrl`

## Requirements
- R1: While and after reset, `sp` equals DEPTH in last-occupied mode (`mode_ne`=0) and DEPTH-1 in next-free mode (`mode_ne`=1). After reset, `empty`=1, `full`=0, `in_ready`=1, `pop_valid`=0 and `err`=0.
- R2: An operation is accepted at a rising edge where `in_valid` and `in_ready` are both high. `in_op`=0 means push and `in_op`=1 means pop. After a legal operation is accepted, `in_ready` is low for the next two cycles and high again in the third.
- R3: A last-occupied push lowers `sp` by one at the second edge after acceptance. At the third edge it writes the data word at the new `sp`, and `sp` stays at that value.
- R4: A last-occupied pop reads the RAM at the current `sp` at the second edge after acceptance, so `pop_valid` is high in the cycle that follows. At the third edge `sp` rises by one.
- R5: A next-free push writes the data word at the current `sp` at the second edge after acceptance. At the third edge `sp` falls by one.
- R6: A next-free pop raises `sp` by one at the second edge after acceptance and reads at that new address at the third edge, so `pop_valid` is high in the cycle after the third edge.
- R7: In both modes, pops return data words in the reverse order of the pushes that stored them.
- R8: `empty` is high exactly when no words are stored, and `full` is high exactly when DEPTH words are stored. Both flags change at the third edge after acceptance. In next-free mode a full stack leaves `sp` at all ones.
- R9: A push while `full` or a pop while `empty` is rejected. `err` is high for exactly one cycle after the accepting edge, and `in_ready` stays high. `sp`, the flags and the stored words are unchanged.
- R10: `pop_valid` is a single-cycle strobe and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_ne | input | 1 | Static convention select: 0 last-occupied, 1 next-free |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Controller can accept a request |
| in_op | input | 1 | 0 push, 1 pop |
| in_data | input | DATA_W | Word to push |
| pop_data | output | DATA_W | Popped word, meaningful while pop_valid is high |
| pop_valid | output | 1 | One-cycle strobe marking pop_data |
| sp | output | $clog2(DEPTH)+1 | Current stack pointer |
| full | output | 1 | DEPTH words stored |
| empty | output | 1 | No words stored |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Each result is due at a fixed edge counted from the accepting edge E. `err` is due right after E. The intermediate pointer and the last-occupied pop strobe are due after E+1. The final pointer, the flags, the return of `in_ready` and the next-free pop strobe are due after E+2. The bench drives inputs on falling edges and samples each of these values on the falling edge that lies inside the cycle where it is due. A scoreboard queue receives the expected pop word at acceptance. A monitor compares that word whenever the strobe rises, so data order is checked independently of the per-operation timing checks.

// File: rtl/lifo_sp_pkg.sv
package lifo_sp_pkg;

  typedef enum logic {
    OP_PUSH = 1'b0,
    OP_POP  = 1'b1
  } stk_op_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } stk_phase_t;

endpackage

// File: rtl/lifo_sp_ram.sv
module lifo_sp_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end

endmodule

// File: rtl/lifo_sp_ptr.sv
module lifo_sp_ptr #(
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH) + 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ne,
  input  logic             ptr_dec,
  input  logic             ptr_inc,
  input  logic             occ_up,
  input  logic             occ_dn,
  output logic [PTR_W-1:0] sp,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] SP_TOP   = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] SP_ABOVE = PTR_W'(DEPTH);
  localparam logic [OCC_W-1:0] OCC_MAX  = OCC_W'(DEPTH);

  logic [OCC_W-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= mode_ne ? SP_TOP : SP_ABOVE;
    end else if (ptr_dec) begin
      sp <= sp - 1'b1;
    end else if (ptr_inc) begin
      sp <= sp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
    end else if (occ_up) begin
      occ <= occ + 1'b1;
    end else if (occ_dn) begin
      occ <= occ - 1'b1;
    end
  end

  assign full  = (occ == OCC_MAX);
  assign empty = (occ == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_up |-> (occ != OCC_MAX)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ_dn |-> (occ != '0)); // R9
  AST_ONE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ptr_inc, ptr_dec, occ_up, occ_dn}) || (ptr_inc && occ_dn && !ptr_dec && !occ_up)
      || (ptr_dec && occ_up && !ptr_inc && !occ_dn)); // R2

endmodule

// File: rtl/lifo_sp_seq.sv
module lifo_sp_seq
  import lifo_sp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ne,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              full,
  input  logic              empty,
  output logic              ptr_dec,
  output logic              ptr_inc,
  output logic              occ_up,
  output logic              occ_dn,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              err
);

  stk_phase_t        phase;
  stk_op_t           op_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              reject;

  assign in_ready = (phase == PH_IDLE);
  assign accept   = in_valid && in_ready;
  assign reject   = accept && ((stk_op_t'(in_op) == OP_PUSH && full) ||
                               (stk_op_t'(in_op) == OP_POP  && empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      op_q   <= OP_PUSH;
      data_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= reject;
      unique case (phase)
        PH_IDLE: begin
          if (accept && !reject) begin
            phase  <= PH_FIRST;
            op_q   <= stk_op_t'(in_op);
            data_q <= in_data;
          end
        end
        PH_FIRST:  phase <= PH_SECOND;
        PH_SECOND: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  // Step order: last-occupied push moves then writes, pop reads then moves;
  // next-free reverses both.
  always_comb begin
    ptr_dec = 1'b0;
    ptr_inc = 1'b0;
    occ_up  = 1'b0;
    occ_dn  = 1'b0;
    mem_we  = 1'b0;
    mem_re  = 1'b0;
    if (phase == PH_FIRST) begin
      if (op_q == OP_PUSH) begin
        if (mode_ne) mem_we = 1'b1;
        else         ptr_dec = 1'b1;
      end else begin
        if (mode_ne) ptr_inc = 1'b1;
        else         mem_re = 1'b1;
      end
    end else if (phase == PH_SECOND) begin
      if (op_q == OP_PUSH) begin
        occ_up = 1'b1;
        if (mode_ne) ptr_dec = 1'b1;
        else         mem_we = 1'b1;
      end else begin
        occ_dn = 1'b1;
        if (mode_ne) mem_re = 1'b1;
        else         ptr_inc = 1'b1;
      end
    end
  end

  assign mem_wdata = data_q;

  AST_ERR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> in_ready); // R9
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !reject) |=> !in_ready ##1 !in_ready ##1 in_ready); // R2

endmodule

// File: rtl/lifo_sp_ctrl.sv
module lifo_sp_ctrl #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ne,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] pop_data,
  output logic              pop_valid,
  output logic [PTR_W-1:0]  sp,
  output logic              full,
  output logic              empty,
  output logic              err
);

  localparam logic [PTR_W-1:0] SP_TOP   = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] SP_ABOVE = PTR_W'(DEPTH);

  logic              ptr_dec, ptr_inc, occ_up, occ_dn;
  logic              mem_we, mem_re;
  logic [DATA_W-1:0] mem_wdata;

  lifo_sp_seq #(.DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .mode_ne(mode_ne),
    .in_valid(in_valid), .in_op(in_op), .in_data(in_data), .in_ready(in_ready),
    .full(full), .empty(empty),
    .ptr_dec(ptr_dec), .ptr_inc(ptr_inc), .occ_up(occ_up), .occ_dn(occ_dn),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .err(err)
  );

  lifo_sp_ptr #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .mode_ne(mode_ne),
    .ptr_dec(ptr_dec), .ptr_inc(ptr_inc), .occ_up(occ_up), .occ_dn(occ_dn),
    .sp(sp), .full(full), .empty(empty)
  );

  lifo_sp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .we(mem_we), .re(mem_re), .addr(sp[AW-1:0]),
    .wdata(mem_wdata), .rdata(pop_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_valid <= 1'b0;
    else        pop_valid <= mem_re;
  end

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R7
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (sp < SP_ABOVE)); // R8
  AST_EMPTY_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && empty) |-> (sp == (mode_ne ? SP_TOP : SP_ABOVE))); // R1
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R8
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> !pop_valid); // R10
  AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $stable(sp)); // R9

endmodule

// File: tb/lifo_sp_ctrl_tb_top.sv
`timescale 1ns/1ps
module lifo_sp_ctrl_tb_top;

  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_ne = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_op = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, pop_valid, full, empty, err;
  logic [DW-1:0] pop_data;
  logic [PW-1:0] sp;

  lifo_sp_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ne(mode_ne),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_data(in_data),
    .pop_data(pop_data), .pop_valid(pop_valid), .sp(sp),
    .full(full), .empty(empty), .err(err)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] mon_e;
  logic [PW-1:0] sp_m;
  bit            prev_valid = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each strobed word against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (pop_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected pop strobe", int'(pop_data), 0);
        end else begin
          mon_e = exp_q.pop_front();
          chk(pop_data == mon_e, "R7 pop order", int'(pop_data), int'(mon_e));
        end
        chk(!prev_valid, "R10 strobe length", 1, 0);
      end
      prev_valid = pop_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic do_reset(input bit ne);
    @(negedge clk);
    mode_ne  = ne;
    in_valid = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    chk(sp == (ne ? PW'(DEPTH - 1) : PW'(DEPTH)), "R1 pointer in reset", int'(sp),
        ne ? DEPTH - 1 : DEPTH);
    rst_n = 1'b1;
    model.delete();
    sp_m = ne ? PW'(DEPTH - 1) : PW'(DEPTH);
    @(negedge clk);
    chk(sp == sp_m, "R1 pointer after reset", int'(sp), int'(sp_m));
    chk(empty && !full, "R1 flags", {full, empty}, 1);
    chk(in_ready && !pop_valid && !err, "R1 handshake idle", {in_ready, pop_valid, err}, 4);
  endtask

  task automatic do_op(input bit is_pop, input logic [DW-1:0] d);
    bit rej;
    logic [PW-1:0] old_sp, mid_sp, fin_sp;
    string tag;
    rej = is_pop ? (model.size() == 0) : (model.size() == DEPTH);
    old_sp = sp_m;
    if (is_pop) begin
      mid_sp = mode_ne ? old_sp + 1'b1 : old_sp;
      fin_sp = old_sp + 1'b1;
      tag = mode_ne ? "R6" : "R4";
    end else begin
      mid_sp = mode_ne ? old_sp : old_sp - 1'b1;
      fin_sp = old_sp - 1'b1;
      tag = mode_ne ? "R5" : "R3";
    end
    in_valid = 1'b1;
    in_op    = is_pop;
    in_data  = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (rej) begin
      chk(err == 1'b1, "R9 error pulse", int'(err), 1);
      chk(in_ready == 1'b1, "R9 ready held", int'(in_ready), 1);
      chk(sp == old_sp, "R9 pointer kept", int'(sp), int'(old_sp));
      @(negedge clk);
      chk(err == 1'b0, "R9 pulse width", int'(err), 0);
      chk(sp == old_sp, "R9 pointer still kept", int'(sp), int'(old_sp));
      chk(full == (model.size() == DEPTH) && empty == (model.size() == 0),
          "R9 flags kept", {full, empty}, {model.size() == DEPTH, model.size() == 0});
      return;
    end
    chk(in_ready == 1'b0, "R2 busy first cycle", int'(in_ready), 0);
    chk(err == 1'b0, "R9 no error on legal op", int'(err), 0);
    chk(sp == old_sp, {tag, " pointer before first step"}, int'(sp), int'(old_sp));
    if (is_pop) begin
      exp_q.push_back(model[$]);
      void'(model.pop_back());
    end else begin
      model.push_back(d);
    end
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 busy second cycle", int'(in_ready), 0);
    chk(sp == mid_sp, {tag, " pointer after first step"}, int'(sp), int'(mid_sp));
    chk(pop_valid == (is_pop && !mode_ne), {tag, " strobe after first step"},
        int'(pop_valid), int'(is_pop && !mode_ne));
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready returns", int'(in_ready), 1);
    chk(sp == fin_sp, {tag, " pointer after second step"}, int'(sp), int'(fin_sp));
    chk(pop_valid == (is_pop && mode_ne), {tag, " strobe after second step"},
        int'(pop_valid), int'(is_pop && mode_ne));
    chk(full == (model.size() == DEPTH), "R8 full flag", int'(full), int'(model.size() == DEPTH));
    chk(empty == (model.size() == 0), "R8 empty flag", int'(empty), int'(model.size() == 0));
    sp_m = fin_sp;
  endtask

  task automatic run_seq(input int salt);
    do_op(1'b1, '0);
    for (int i = 0; i < DEPTH; i++) do_op(1'b0, DW'(16'h0A00 + i * 37 + salt));
    chk(sp == (mode_ne ? {PW{1'b1}} : '0), "R8 pointer when full", int'(sp),
        mode_ne ? (1 << PW) - 1 : 0);
    do_op(1'b0, 16'hDEAD);
    for (int i = 0; i < 3; i++) do_op(1'b1, '0);
    do_op(1'b0, DW'(16'h5500 + salt));
    do_op(1'b0, DW'(16'h66AA + salt));
    for (int i = 0; i < DEPTH - 1; i++) do_op(1'b1, '0);
    do_op(1'b1, '0);
    chk(exp_q.size() == 0, "R7 all pops returned", exp_q.size(), 0);
  endtask

  initial begin
    do_reset(1'b0);
    run_seq(0);
    do_reset(1'b1);
    run_seq(3);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule